// File: doc/BRIEF.md
# Two-Bank SDRAM Command Sequencer

This block sits between a simple single-word host request port and a synchronous DRAM with two banks. Each host request carries a bank bit, a row, a column, a direction flag and write data. The block turns each request into an activate, one column read or write, and a precharge of that bank. Every command goes out as a registered pattern on the four active-low strobes (chip select, row strobe, column strobe, write enable), along with a separate bank-select pin and a shared row/column address bus.

After reset the sequencer waits a set number of cycles and closes all banks. It then loads the device mode register with the configured read latency, a burst length of one, and the chosen wrap order. Only after that does it accept host traffic. A free-running interval counter flags when a refresh is due. The flag is served once the access in flight has finished: the block closes every bank, waits out the precharge time, and issues an auto-refresh.

Read data arrives on the data input the configured latency after the read command. The block captures it and presents it to the host with a one-cycle valid pulse. The minimum activate-to-column and precharge-to-activate spacings are parameters, and the block fills them with NOP cycles.

Top module: `sdram_ctrl`

## Requirements
- R1: After reset, no activate, read or write is issued before the mode-set command. The mode-set is preceded by a precharge with address bit 10 high (all banks). It carries the read latency in address bits 6:4, the wrap order in bit 3 (1 = interleaved), and burst code 000 in bits 2:0.
- R2: Commands appear on {csN,rasN,casN,weN} as: activate 0011, read 0101, write 0100, precharge 0010, auto-refresh 0001, mode-set 0000, idle 0111. The pins show the idle code during and after reset until the first command.
- R3: An accepted request produces three commands, with host address laid out as {bank, row, col}. First an activate with the row on the address bus. Then a read or write matching the request, with the column in the low address bits and bit 10 low. Then a precharge of the same bank with bit 10 low.
- R4: A read or write follows its activate by exactly T_RCD cycles.
- R5: An activate follows the previous precharge by at least T_RP cycles.
- R6: Read data sampled on the data input CAS_LAT cycles after the read command cycle is presented on rdData, with rdValid high for exactly one cycle, CAS_LAT+1 cycles after the read command.
- R7: The data output enable is high only in a write command cycle, and the data output then carries the request's write data.
- R8: Auto-refresh is issued at least once per REF_INTERVAL cycles, plus the length of one access. Each refresh comes at least T_RP cycles after an all-bank precharge.
- R9: reqReady is high only while the sequencer is idle, initialised and has no refresh due. A request is accepted in a cycle with reqValid and reqReady both high. Each accepted request yields exactly one activate.
- R10: The request's bank bit drives the bank-select pin for the activate, the column command and the single-bank precharge. Same row and column in the two banks are distinct storage.

Parameters: ROW_W, COL_W, DATA_W, CAS_LAT, WRAP_IL, T_RCD, T_RP, T_WR, T_RFC, T_MRD, INIT_CYCLES, REF_INTERVAL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 1+ROW_W+COL_W | {bank, row, col} |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Request accepted this cycle when reqValid is high |
| rdValid | output | 1 | Read data valid pulse |
| rdData | output | DATA_W | Read data |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memBank | output | 1 | Bank select |
| memAddr | output | ROW_W | Multiplexed row/column/mode address |
| memDqOut | output | DATA_W | Write data to device |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | DATA_W | Read data from device |

## Verification
Writes land in both banks at the same row and column, then at the highest row and column, and are read back. This tells apart a bank bit that is ignored or swapped from one that is honoured, and catches truncated row or column fields. A later overwrite of an earlier location, read back again, separates real data paths from stale captures. Outside the read window the bench model drives a poison value on the data input, so a capture taken one cycle early or late shows up as wrong data. A long idle stretch at the end lets several refresh intervals run out. This checks refresh spacing and the all-bank precharge ahead of each refresh against the same traffic timing.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

  // value equals the {csN,rasN,casN,weN} pin pattern
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROW,
    SEL_COL,
    SEL_MODE,
    SEL_ALL,
    SEL_BANK
  } addr_sel_t;

  typedef struct packed {
    cmd_t      cmd;
    addr_sel_t sel;
    logic      capture;
  } strobe_t;

endpackage

// File: rtl/sdram_ctrl_seq.sv
module sdram_ctrl_seq
  import sdram_ctrl_pkg::*;
#(
  parameter int CAS_LAT      = 2,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_WR         = 2,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int INIT_CYCLES  = 20,
  parameter int REF_INTERVAL = 1560
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int MAXG   = (INIT_CYCLES > 255) ? INIT_CYCLES : 255;
  localparam int WAIT_W = $clog2(MAXG + 1);
  localparam int RC_W   = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

  typedef enum logic [3:0] {
    S_WAIT, S_PREALL, S_MRS, S_IDLE, S_ACT, S_COL, S_PRE, S_REF
  } state_t;

  state_t            state, nState, retState, nRet, tgt;
  logic [WAIT_W-1:0] waitCnt, nCnt, gap;
  logic              jump;
  logic              modeDone, refPending, isWrite;
  logic [RC_W-1:0]   refCnt;

  always_comb begin
    stb      = '{cmd: CMD_NOP, sel: SEL_NONE, capture: 1'b0};
    nState   = state;
    nCnt     = waitCnt;
    nRet     = retState;
    jump     = 1'b0;
    gap      = '0;
    tgt      = S_IDLE;
    reqReady = (state == S_IDLE) && modeDone && !refPending;
    case (state)
      S_WAIT: begin
        if (waitCnt == '0) nState = retState;
        else nCnt = waitCnt - 1'b1;
      end
      S_IDLE: begin
        if (refPending) nState = S_PREALL;
        else if (reqValid && modeDone) begin
          stb.capture = 1'b1;
          nState      = S_ACT;
        end
      end
      S_PREALL: begin
        stb.cmd = CMD_PRE; stb.sel = SEL_ALL;
        jump = 1'b1; gap = WAIT_W'(T_RP);
        tgt  = modeDone ? S_REF : S_MRS;
      end
      S_MRS: begin
        stb.cmd = CMD_MRS; stb.sel = SEL_MODE;
        jump = 1'b1; gap = WAIT_W'(T_MRD); tgt = S_IDLE;
      end
      S_REF: begin
        stb.cmd = CMD_REF;
        jump = 1'b1; gap = WAIT_W'(T_RFC); tgt = S_IDLE;
      end
      S_ACT: begin
        stb.cmd = CMD_ACT; stb.sel = SEL_ROW;
        jump = 1'b1; gap = WAIT_W'(T_RCD); tgt = S_COL;
      end
      S_COL: begin
        stb.cmd = isWrite ? CMD_WR : CMD_RD; stb.sel = SEL_COL;
        jump = 1'b1; gap = isWrite ? WAIT_W'(T_WR) : WAIT_W'(CAS_LAT);
        tgt  = S_PRE;
      end
      S_PRE: begin
        stb.cmd = CMD_PRE; stb.sel = SEL_BANK;
        jump = 1'b1; gap = WAIT_W'(T_RP); tgt = S_IDLE;
      end
      default: nState = S_IDLE;
    endcase
    if (jump) begin
      if (gap > WAIT_W'(1)) begin
        nState = S_WAIT;
        nCnt   = gap - WAIT_W'(2);
        nRet   = tgt;
      end else begin
        nState = tgt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_WAIT;
      waitCnt    <= WAIT_W'(INIT_CYCLES - 1);
      retState   <= S_PREALL;
      modeDone   <= 1'b0;
      refPending <= 1'b0;
      isWrite    <= 1'b0;
      refCnt     <= RC_W'(REF_INTERVAL - 1);
    end else begin
      state    <= nState;
      waitCnt  <= nCnt;
      retState <= nRet;
      if (state == S_MRS) modeDone <= 1'b1;
      if (stb.capture) isWrite <= reqWrite;
      if (refCnt == '0) begin
        refCnt     <= RC_W'(REF_INTERVAL - 1);
        refPending <= 1'b1;
      end else begin
        refCnt <= refCnt - 1'b1;
        if (state == S_REF) refPending <= 1'b0;
      end
    end
  end

  AST_MODE_BEFORE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmd == CMD_ACT || stb.cmd == CMD_RD || stb.cmd == CMD_WR) |-> modeDone); // R1

  AST_ACCEPT_STARTS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (stb.cmd == CMD_ACT)); // R9

endmodule

// File: rtl/sdram_ctrl_dp.sv
module sdram_ctrl_dp
  import sdram_ctrl_pkg::*;
#(
  parameter int ROW_W   = 11,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 2,
  parameter bit WRAP_IL = 1'b0,
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [ROW_W+COL_W:0]     reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     rdValid,
  output logic [DATA_W-1:0]        rdData,
  output logic                     memCsN,
  output logic                     memRasN,
  output logic                     memCasN,
  output logic                     memWeN,
  output logic                     memBank,
  output logic [ROW_W-1:0]         memAddr,
  output logic [DATA_W-1:0]        memDqOut,
  output logic                     memDqOe,
  input  logic [DATA_W-1:0]        memDqIn
);

  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'(((CAS_LAT & 7) << 4) | (int'(WRAP_IL) << 3));

  logic              bankQ;
  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic [DATA_W-1:0] wdataQ;
  cmd_t              cmdQ;
  logic [ROW_W-1:0]  nAddr;
  logic              nBank;
  logic [CAS_LAT-1:0] rdPipe;

  assign {memCsN, memRasN, memCasN, memWeN} = cmdQ;

  always_comb begin
    nAddr = '0;
    nBank = 1'b0;
    case (stb.sel)
      SEL_ROW:  begin nAddr = rowQ; nBank = bankQ; end
      SEL_COL:  begin nAddr = ROW_W'(colQ); nBank = bankQ; end
      SEL_MODE: nAddr = MODE_WORD;
      SEL_ALL:  nAddr[10] = 1'b1;
      SEL_BANK: nBank = bankQ;
      default:  nAddr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ <= 1'b0; rowQ <= '0; colQ <= '0; wdataQ <= '0;
      cmdQ <= CMD_NOP; memAddr <= '0; memBank <= 1'b0;
      memDqOut <= '0; memDqOe <= 1'b0;
    end else begin
      if (stb.capture) begin
        {bankQ, rowQ, colQ} <= reqAddr;
        wdataQ <= reqWdata;
      end
      cmdQ     <= stb.cmd;
      memAddr  <= nAddr;
      memBank  <= nBank;
      memDqOe  <= (stb.cmd == CMD_WR);
      memDqOut <= wdataQ;
    end
  end

  generate
    if (CAS_LAT == 1) begin : g_pipe1
      always_ff @(posedge clk) begin
        if (!rstN) rdPipe <= '0;
        else rdPipe <= (cmdQ == CMD_RD);
      end
    end else begin : g_pipeN
      always_ff @(posedge clk) begin
        if (!rstN) rdPipe <= '0;
        else rdPipe <= {rdPipe[CAS_LAT-2:0], (cmdQ == CMD_RD)};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdPipe[CAS_LAT-1];
      if (rdPipe[CAS_LAT-1]) rdData <= memDqIn;
    end
  end

  logic [7:0] sinceAct, sincePre, sincePreAll;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct <= 8'hff; sincePre <= 8'hff; sincePreAll <= 8'hff;
    end else begin
      sinceAct    <= (cmdQ == CMD_ACT) ? 8'd1 : ((sinceAct == 8'hff) ? sinceAct : sinceAct + 8'd1);
      sincePre    <= (cmdQ == CMD_PRE) ? 8'd1 : ((sincePre == 8'hff) ? sincePre : sincePre + 8'd1);
      sincePreAll <= (cmdQ == CMD_PRE && memAddr[10]) ? 8'd1 :
                     ((sincePreAll == 8'hff) ? sincePreAll : sincePreAll + 8'd1);
    end
  end

  AST_COL_AFTER_ACT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_RD || cmdQ == CMD_WR) |-> (sinceAct >= 8'(T_RCD))); // R4

  AST_ACT_AFTER_PRE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_ACT) |-> (sincePre >= 8'(T_RP))); // R5

  AST_REF_AFTER_PREALL: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_REF) |-> (sincePreAll >= 8'(T_RP))); // R8

  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R6

endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 16,
  parameter int CAS_LAT      = 2,
  parameter bit WRAP_IL      = 1'b0,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_WR         = 2,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int INIT_CYCLES  = 20,
  parameter int REF_INTERVAL = 1560
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W:0]   reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   reqReady,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData,
  output logic                   memCsN,
  output logic                   memRasN,
  output logic                   memCasN,
  output logic                   memWeN,
  output logic                   memBank,
  output logic [ROW_W-1:0]       memAddr,
  output logic [DATA_W-1:0]      memDqOut,
  output logic                   memDqOe,
  input  logic [DATA_W-1:0]      memDqIn
);

  strobe_t stb;

  sdram_ctrl_seq #(
    .CAS_LAT(CAS_LAT), .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .INIT_CYCLES(INIT_CYCLES),
    .REF_INTERVAL(REF_INTERVAL)
  ) uSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  sdram_ctrl_dp #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CAS_LAT(CAS_LAT),
    .WRAP_IL(WRAP_IL), .T_RCD(T_RCD), .T_RP(T_RP)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData),
    .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memBank(memBank), .memAddr(memAddr), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

endmodule

// File: tb/sim_sdram_ctrl.sv
module sim_sdram_ctrl;

  localparam int CLK_PERIOD   = 10;
  localparam int ROW_W        = 11;
  localparam int COL_W        = 8;
  localparam int DATA_W       = 16;
  localparam int CL           = 2;
  localparam int T_RCD        = 3;
  localparam int T_RP         = 2;
  localparam int T_WR         = 2;
  localparam int T_RFC        = 6;
  localparam int T_MRD        = 2;
  localparam int INIT_CYCLES  = 10;
  localparam int REF_INTERVAL = 300;
  localparam int SLACK        = 60;
  localparam int NVEC         = 8;

  // {write, bank, row, col, data}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 11'd5,    8'd0,   16'hA5A5},
    {1'b1, 1'b1, 11'd5,    8'd0,   16'h5A5A},
    {1'b1, 1'b0, 11'd2047, 8'd255, 16'h1234},
    {1'b1, 1'b1, 11'd0,    8'd255, 16'hFEDC},
    {1'b0, 1'b0, 11'd5,    8'd0,   16'hA5A5},
    {1'b0, 1'b1, 11'd5,    8'd0,   16'h5A5A},
    {1'b0, 1'b0, 11'd2047, 8'd255, 16'h1234},
    {1'b0, 1'b1, 11'd0,    8'd255, 16'hFEDC}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ROW_W+COL_W:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0, memDqIn = 16'hDEAD;
  logic reqReady, rdValid, memCsN, memRasN, memCasN, memWeN, memBank, memDqOe;
  logic [DATA_W-1:0] rdData, memDqOut;
  logic [ROW_W-1:0] memAddr;

  sdram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CAS_LAT(CL), .WRAP_IL(1'b0),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .INIT_CYCLES(INIT_CYCLES), .REF_INTERVAL(REF_INTERVAL)
  ) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // current request, set by the driver
  logic curWr = 0, curBank = 0;
  logic [ROW_W-1:0] curRow = '0;
  logic [COL_W-1:0] curCol = '0;
  logic [DATA_W-1:0] curData = '0;

  logic [DATA_W-1:0] mem [logic [19:0]];
  int lastAct = -1000, lastPre = -1000, lastPreAll = -1000, lastRef = 0;
  int rdDue = -1, rdPin = -1000;
  logic [DATA_W-1:0] rdVal = '0;
  bit mrsSeen = 0, preAllBeforeMrs = 0;
  int actCount = 0, refCount = 0, rdCount = 0, busyReady = 0, oeViol = 0;

  // device model and monitor
  always @(negedge clk) begin
    logic [3:0] cmd;
    logic [19:0] key;
    cmd = {memCsN, memRasN, memCasN, memWeN};
    if (rstN) begin
      if (cmd != 4'b0111 && reqReady) busyReady++;
      if (memDqOe && cmd != 4'b0100) oeViol++;
      case (cmd)
        4'b0010: begin
          if (memAddr[10]) begin
            lastPreAll = cyc;
            if (!mrsSeen) preAllBeforeMrs = 1;
          end else begin
            chk(memBank == curBank, "R10 precharge bank", 32'(memBank), 32'(curBank));
          end
          lastPre = cyc;
        end
        4'b0000: begin
          chk(preAllBeforeMrs, "R1 precharge-all before mode set", 0, 1);
          chk(memAddr == ROW_W'(CL << 4), "R1 mode word", 32'(memAddr), 32'(CL << 4));
          mrsSeen = 1;
        end
        4'b0001: begin
          chk(cyc - lastPreAll >= T_RP, "R8 refresh after precharge-all", cyc - lastPreAll, T_RP);
          chk(cyc - lastRef <= REF_INTERVAL + INIT_CYCLES + SLACK, "R8 refresh spacing",
              cyc - lastRef, REF_INTERVAL + SLACK);
          lastRef = cyc;
          refCount++;
        end
        4'b0011: begin
          chk(mrsSeen, "R1 activate after mode set", 0, 1);
          chk(memBank == curBank, "R10 activate bank", 32'(memBank), 32'(curBank));
          chk(memAddr == curRow, "R3 activate row", 32'(memAddr), 32'(curRow));
          chk(cyc - lastPre >= T_RP, "R5 precharge to activate", cyc - lastPre, T_RP);
          lastAct = cyc;
          actCount++;
        end
        4'b0100, 4'b0101: begin
          chk(cyc - lastAct == T_RCD, "R4 activate to column", cyc - lastAct, T_RCD);
          chk(memAddr == ROW_W'(curCol) && (cmd == 4'b0100) == curWr && memBank == curBank,
              "R3 column command", {memBank, 4'(cmd), 16'(memAddr)},
              {curBank, curWr ? 4'b0100 : 4'b0101, 16'(curCol)});
          key = {memBank, curRow, memAddr[COL_W-1:0]};
          if (cmd == 4'b0100) begin
            chk(memDqOe && memDqOut == curData, "R7 write data", {memDqOe, memDqOut}, {1'b1, curData});
            mem[key] = memDqOut;
          end else begin
            rdDue = cyc + CL;
            rdPin = cyc;
            rdVal = mem.exists(key) ? mem[key] : 16'hBAD0;
          end
        end
        default: ;
      endcase
      if (rdValid) begin
        chk(cyc == rdPin + CL + 1, "R6 read latency", cyc - rdPin, CL + 1);
        chk(rdData == curData, "R6 read data", rdData, curData);
        rdCount++;
      end
      memDqIn = (cyc == rdDue) ? rdVal : 16'hDEAD;
    end
  end

  int reqCount = 0, readCount = 0;

  task automatic doReq(input logic [36:0] v);
    @(negedge clk);
    {curWr, curBank, curRow, curCol, curData} = v;
    reqWrite = curWr;
    reqAddr  = {curBank, curRow, curCol};
    reqWdata = curData;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqCount++;
    if (!curWr) readCount++;
    repeat (20 + CL) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk({memCsN, memRasN, memCasN, memWeN} == 4'b0111, "R2 idle pins in reset",
        {memCsN, memRasN, memCasN, memWeN}, 4'b0111);
    chk(!reqReady && !rdValid && !memDqOe, "R9 outputs quiet in reset",
        {reqReady, rdValid, memDqOe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!reqReady, "R1 not ready before mode set", reqReady, 0);

    // vector table
    for (int i = 0; i < NVEC; i++) doReq(VEC[i]);

    // overwrite one location and read it back
    doReq({1'b1, 1'b0, 11'd5, 8'd0, 16'h0F0F});
    doReq({1'b0, 1'b0, 11'd5, 8'd0, 16'h0F0F});
    // other bank untouched
    doReq({1'b0, 1'b1, 11'd5, 8'd0, 16'h5A5A});

    // let several refresh intervals run out
    repeat (3 * REF_INTERVAL) @(negedge clk);
    chk(refCount >= cyc / (REF_INTERVAL + SLACK), "R8 refresh count", refCount, cyc / (REF_INTERVAL + SLACK));
    chk(actCount == reqCount, "R9 one activate per request", actCount, reqCount);
    chk(rdCount == readCount, "R6 one data pulse per read", rdCount, readCount);
    chk(busyReady == 0, "R9 ready while commands issue", busyReady, 0);
    chk(oeViol == 0, "R7 output enable outside write", oeViol, 0);
    chk({memCsN, memRasN, memCasN, memWeN} != 4'b1111, "R2 chip selected idle",
        {memCsN, memRasN, memCasN, memWeN}, 4'b0111);
    finish();
  end

endmodule